// File: doc/BRIEF.md
# GPIO Controller with Edge-Triggered Interrupts

This block is a general-purpose I/O peripheral with up to 32 pins behind a simple Wishbone-style register bus. Software sets the pin values and a per-pin drive enable. It can hand any output pin over to an auxiliary on-chip source. It reads the pin levels back through an input register that merges in the driven value.

The block samples input pins after a synchronizer. The sampling event is either every system clock, or a chosen edge of an external sampling clock that is synchronized into the same domain. On each sampling event the block compares the new captured input with the previous one. Per pin, it picks rising or falling transitions. Enabled events collect in a sticky status register and raise one level interrupt, which stays high until software clears the pending flag.

Top module: `gpio_edge_ctrl`

Word map (byte offset): 0x00 captured input, 0x04 output value, 0x08 drive enable, 0x0C interrupt mask, 0x10 polarity, 0x14 auxiliary select, 0x18 control, 0x1C event status. Control bits: bit 0 global interrupt enable, bit 1 interrupt pending, bit 2 external sampling clock select, bit 3 falling-edge select.

## Requirements
- R1: A write to offsets 0x04 to 0x1C stores the value and a read returns it unchanged. A read of any word offset of 0x20 or above returns zero.
- R2: A write to offset 0x00 has no effect. A read of offset 0x00 returns the captured input ORed with the output register.
- R3: On each sampling event, gpio_o takes ((OUT & ~AUXSEL) | (aux_i & AUXSEL)) & OE, using register values from before that edge. gpio_oe_o always equals the drive-enable register.
- R4: In system-clock sampling mode, a change on gpio_i shows in the captured input register after the third rising clock edge. Bits whose drive enable is 1 are captured as 0.
- R5: Events are detected only while control bit 0 is 1. A bit with polarity 1 fires when its captured value goes 0 to 1. A bit with polarity 0 fires when it goes 1 to 0.
- R6: Fired bits ANDed with the interrupt mask are ORed into the status register, which keeps them. If any such bit is set, control bit 1 is set. irq_o equals control bit 1.
- R7: With control bit 2 at 0, sampling happens on every clock. With control bit 2 at 1, sampling happens only when the synchronized ext_clk_i changes. Between events, gpio_o and the captured input hold.
- R8: With an external sampling clock, control bit 3 at 0 samples on a low-to-high change of ext_clk_i, and control bit 3 at 1 samples on a high-to-low change.
- R9: Software clears status and pending bits by writing the status and control registers. A new event in the same cycle as such a write still sets its bits.
- R10: The block accepts a request when cyc and stb are high and ack is low. wb_ack_o is a one-cycle pulse on the next cycle, and read data is valid with it.
- R11: After reset, every register is zero and gpio_o, irq_o and wb_ack_o are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_i | input | 1 | Synchronous reset, active high |
| wb_cyc_i | input | 1 | Bus cycle valid |
| wb_stb_i | input | 1 | Bus strobe |
| wb_we_i | input | 1 | Write when high, read when low |
| wb_adr_i | input | ADR_W-2 | Word address (byte address bits ADR_W-1:2) |
| wb_dat_i | input | 32 | Write data |
| wb_dat_o | output | 32 | Read data, valid with ack |
| wb_ack_o | output | 1 | Transfer acknowledge |
| gpio_i | input | GPIO_W | Asynchronous input pins |
| aux_i | input | GPIO_W | Auxiliary output source |
| ext_clk_i | input | 1 | Asynchronous external sampling clock |
| gpio_o | output | GPIO_W | Driven pin values |
| gpio_oe_o | output | GPIO_W | Per-pin drive enable |
| irq_o | output | 1 | Level interrupt |

## Verification
Each result has its own latency. A bus ack and read data come one edge after acceptance. A register write takes effect at that same edge, and gpio_o follows at the next sampling event. A pin change reaches the captured input and the interrupt after three edges in system-clock mode. In external mode the delay is three edges after the ext_clk_i transition. The bench does not hard-code these delays. A behavioural model steps through the same edges, keeping the synchronizers as queues, and every output is compared at the falling clock edge, when all registered outputs are stable.

// File: rtl/gpio_pkg.sv
package gpio_pkg;
   localparam int unsigned BUS_W = 32;
   localparam int unsigned CTRL_W = 4;

   typedef enum logic [2:0] {
      RG_IN    = 3'd0,
      RG_OUT   = 3'd1,
      RG_OE    = 3'd2,
      RG_INTE  = 3'd3,
      RG_POL   = 3'd4,
      RG_AUX   = 3'd5,
      RG_CTRL  = 3'd6,
      RG_STAT  = 3'd7
   } reg_idx_e;

   localparam int unsigned CB_IE   = 0;
   localparam int unsigned CB_PEND = 1;
   localparam int unsigned CB_ECLK = 2;
   localparam int unsigned CB_NEG  = 3;
endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
   parameter int unsigned W      = 32,
   parameter int unsigned STAGES = 2
) (
   input  logic         clk_i,
   input  logic         rst_i,
   input  logic [W-1:0] d_i,
   output logic [W-1:0] q_o
);
   logic [W-1:0] stage_q [STAGES];

   always_ff @(posedge clk_i) begin
      if (rst_i) stage_q[0] <= '0;
      else       stage_q[0] <= d_i;
   end

   for (genvar s = 1; s < STAGES; s++) begin : g_stage
      always_ff @(posedge clk_i) begin
         if (rst_i) stage_q[s] <= '0;
         else       stage_q[s] <= stage_q[s-1];
      end
   end

   assign q_o = stage_q[STAGES-1];
endmodule

// File: rtl/gpio_tick_gen.sv
module gpio_tick_gen (
   input  logic clk_i,
   input  logic rst_i,
   input  logic ext_sync_i,
   input  logic use_ext_i,
   input  logic neg_i,
   output logic tick_o
);
   logic prev_q;
   logic chosen_edge;

   always_ff @(posedge clk_i) begin
      if (rst_i) prev_q <= 1'b0;
      else       prev_q <= ext_sync_i;
   end

   // changed, and the new level is the one the selected edge lands on
   assign chosen_edge = (ext_sync_i ^ prev_q) & (ext_sync_i ^ neg_i);
   assign tick_o      = use_ext_i ? chosen_edge : 1'b1;
endmodule

// File: rtl/gpio_edge_irq.sv
module gpio_edge_irq #(
   parameter int unsigned W = 32
) (
   input  logic         arm_i,
   input  logic [W-1:0] old_i,
   input  logic [W-1:0] new_i,
   input  logic [W-1:0] pol_i,
   input  logic [W-1:0] mask_i,
   output logic [W-1:0] hit_o
);
   logic [W-1:0] rose, fell, wanted;

   always_comb begin
      rose   = new_i & ~old_i;
      fell   = old_i & ~new_i;
      wanted = (rose & pol_i) | (fell & ~pol_i);
      hit_o  = arm_i ? (wanted & mask_i) : '0;
   end
endmodule

// File: rtl/gpio_edge_ctrl.sv
module gpio_edge_ctrl
   import gpio_pkg::*;
#(
   parameter int unsigned GPIO_W      = 32,
   parameter int unsigned ADR_W       = 6,
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic              clk_i,
   input  logic              rst_i,
   input  logic              wb_cyc_i,
   input  logic              wb_stb_i,
   input  logic              wb_we_i,
   input  logic [ADR_W-1:2]  wb_adr_i,
   input  logic [BUS_W-1:0]  wb_dat_i,
   output logic [BUS_W-1:0]  wb_dat_o,
   output logic              wb_ack_o,
   input  logic [GPIO_W-1:0] gpio_i,
   input  logic [GPIO_W-1:0] aux_i,
   input  logic              ext_clk_i,
   output logic [GPIO_W-1:0] gpio_o,
   output logic [GPIO_W-1:0] gpio_oe_o,
   output logic              irq_o
);
   localparam int unsigned WORD_W = ADR_W - 2;

   if (GPIO_W < 1 || GPIO_W > BUS_W) begin : g_bad_width
      $error("gpio_edge_ctrl: GPIO_W must be 1..32");
   end
   if (ADR_W < 5) begin : g_bad_adr
      $error("gpio_edge_ctrl: ADR_W must cover eight words");
   end
   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("gpio_edge_ctrl: SYNC_STAGES must be at least 2");
   end

   logic [GPIO_W-1:0] in_q, out_q, oe_q, inte_q, pol_q, aux_q, stat_q, pin_q;
   logic [CTRL_W-1:0] ctrl_q;
   logic              ack_q;
   logic [BUS_W-1:0]  rdat_q;

   logic [GPIO_W-1:0] in_sync, in_new, hits, stat_nxt, drive_nxt;
   logic              ext_sync, smp_tick;
   logic [CTRL_W-1:0] ctrl_nxt;
   logic              acc, wr, rd, mapped;
   logic [2:0]        ridx;
   logic [BUS_W-1:0]  rmux;

   // synchronizers
   gpio_sync #(.W(GPIO_W), .STAGES(SYNC_STAGES)) u_pin_sync (
      .clk_i (clk_i), .rst_i (rst_i), .d_i (gpio_i), .q_o (in_sync));

   gpio_sync #(.W(1), .STAGES(SYNC_STAGES)) u_clk_sync (
      .clk_i (clk_i), .rst_i (rst_i), .d_i (ext_clk_i), .q_o (ext_sync));

   gpio_tick_gen u_tick (
      .clk_i      (clk_i),
      .rst_i      (rst_i),
      .ext_sync_i (ext_sync),
      .use_ext_i  (ctrl_q[CB_ECLK]),
      .neg_i      (ctrl_q[CB_NEG]),
      .tick_o     (smp_tick));

   assign in_new = in_sync & ~oe_q;

   gpio_edge_irq #(.W(GPIO_W)) u_irq (
      .arm_i  (smp_tick & ctrl_q[CB_IE]),
      .old_i  (in_q),
      .new_i  (in_new),
      .pol_i  (pol_q),
      .mask_i (inte_q),
      .hit_o  (hits));

   // bus decode
   assign acc    = wb_cyc_i & wb_stb_i & ~ack_q;
   assign wr     = acc & wb_we_i;
   assign rd     = acc & ~wb_we_i;
   assign ridx   = wb_adr_i[4:2];

   if (WORD_W > 3) begin : g_upper_dec
      assign mapped = (wb_adr_i[ADR_W-1:5] == '0);
   end else begin : g_flat_dec
      assign mapped = 1'b1;
   end

   function automatic logic [BUS_W-1:0] widen(input logic [GPIO_W-1:0] v);
      return BUS_W'(v);
   endfunction

   always_comb begin
      rmux = '0;
      if (mapped) begin
         unique case (reg_idx_e'(ridx))
            RG_IN:   rmux = widen(in_q | out_q);
            RG_OUT:  rmux = widen(out_q);
            RG_OE:   rmux = widen(oe_q);
            RG_INTE: rmux = widen(inte_q);
            RG_POL:  rmux = widen(pol_q);
            RG_AUX:  rmux = widen(aux_q);
            RG_CTRL: rmux = BUS_W'(ctrl_q);
            RG_STAT: rmux = widen(stat_q);
            default: rmux = '0;
         endcase
      end
   end

   // status and control next state: events win over a same-cycle write
   always_comb begin
      stat_nxt = (wr && mapped && ridx == RG_STAT) ? wb_dat_i[GPIO_W-1:0] : stat_q;
      stat_nxt = stat_nxt | hits;
      ctrl_nxt = (wr && mapped && ridx == RG_CTRL) ? wb_dat_i[CTRL_W-1:0] : ctrl_q;
      if (|hits) ctrl_nxt[CB_PEND] = 1'b1;
      drive_nxt = ((out_q & ~aux_q) | (aux_i & aux_q)) & oe_q;
   end

   always_ff @(posedge clk_i) begin
      if (rst_i) begin
         ack_q  <= 1'b0;
         rdat_q <= '0;
         in_q   <= '0;
         out_q  <= '0;
         oe_q   <= '0;
         inte_q <= '0;
         pol_q  <= '0;
         aux_q  <= '0;
         ctrl_q <= '0;
         stat_q <= '0;
         pin_q  <= '0;
      end else begin
         ack_q  <= acc;
         if (rd) rdat_q <= rmux;
         if (wr && mapped) begin
            unique case (reg_idx_e'(ridx))
               RG_OUT:  out_q  <= wb_dat_i[GPIO_W-1:0];
               RG_OE:   oe_q   <= wb_dat_i[GPIO_W-1:0];
               RG_INTE: inte_q <= wb_dat_i[GPIO_W-1:0];
               RG_POL:  pol_q  <= wb_dat_i[GPIO_W-1:0];
               RG_AUX:  aux_q  <= wb_dat_i[GPIO_W-1:0];
               default: ;
            endcase
         end
         ctrl_q <= ctrl_nxt;
         stat_q <= stat_nxt;
         if (smp_tick) begin
            in_q  <= in_new;
            pin_q <= drive_nxt;
         end
      end
   end

   assign wb_ack_o  = ack_q;
   assign wb_dat_o  = rdat_q;
   assign gpio_o    = pin_q;
   assign gpio_oe_o = oe_q;
   assign irq_o     = ctrl_q[CB_PEND];
endmodule

// File: rtl/gpio_edge_ctrl_chk.sv
module gpio_edge_ctrl_chk
   import gpio_pkg::*;
#(
   parameter int unsigned GPIO_W = 32,
   parameter int unsigned ADR_W  = 6
) (
   input logic              clk_i,
   input logic              rst_i,
   input logic              wb_cyc_i,
   input logic              wb_stb_i,
   input logic              wb_we_i,
   input logic [ADR_W-1:2]  wb_adr_i,
   input logic              wb_ack_o,
   input logic              irq_o,
   input logic              smp_tick,
   input logic [CTRL_W-1:0] ctrl_q,
   input logic [GPIO_W-1:0] in_q,
   input logic [GPIO_W-1:0] stat_q,
   input logic [GPIO_W-1:0] gpio_o
);
   logic take, wr_ctrl, wr_stat;
   assign take    = wb_cyc_i && wb_stb_i && !wb_ack_o;
   assign wr_ctrl = take && wb_we_i && (ADR_W-2)'(wb_adr_i) == (ADR_W-2)'(RG_CTRL);
   assign wr_stat = take && wb_we_i && (ADR_W-2)'(wb_adr_i) == (ADR_W-2)'(RG_STAT);

   p_ack_pulse_r10: assert property (@(posedge clk_i) disable iff (rst_i)
      wb_ack_o |=> !wb_ack_o);

   p_ack_due_r10: assert property (@(posedge clk_i) disable iff (rst_i)
      take |=> wb_ack_o);

   p_irq_holds_r6: assert property (@(posedge clk_i) disable iff (rst_i)
      (irq_o && !wr_ctrl) |=> irq_o);

   p_stat_sticky_r6: assert property (@(posedge clk_i) disable iff (rst_i)
      !wr_stat |=> ((stat_q & $past(stat_q)) == $past(stat_q)));

   p_no_irq_when_off_r5: assert property (@(posedge clk_i) disable iff (rst_i)
      (!ctrl_q[CB_IE] && !irq_o && !wr_ctrl) |=> !irq_o);

   p_hold_between_r7: assert property (@(posedge clk_i) disable iff (rst_i)
      !smp_tick |=> ($stable(in_q) && $stable(gpio_o)));
endmodule

bind gpio_edge_ctrl gpio_edge_ctrl_chk #(.GPIO_W(GPIO_W), .ADR_W(ADR_W)) u_chk (
   .clk_i    (clk_i),
   .rst_i    (rst_i),
   .wb_cyc_i (wb_cyc_i),
   .wb_stb_i (wb_stb_i),
   .wb_we_i  (wb_we_i),
   .wb_adr_i (wb_adr_i),
   .wb_ack_o (wb_ack_o),
   .irq_o    (irq_o),
   .smp_tick (smp_tick),
   .ctrl_q   (ctrl_q),
   .in_q     (in_q),
   .stat_q   (stat_q),
   .gpio_o   (gpio_o)
);

// File: tb/gpio_edge_ctrl_tb.sv
module gpio_edge_ctrl_tb;
   localparam int SYNC = 2;

   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic        cyc = 0, stb = 0, we = 0;
   logic [3:0]  adr = '0;
   logic [31:0] wdat = '0;
   logic [31:0] rdat;
   logic        ack;
   logic [31:0] pins = '0, auxv = '0;
   logic        eclk = 1'b0;
   logic [31:0] gout, goe;
   logic        irq;

   int vectors = 0;
   int fails   = 0;
   int ticks   = 0;
   string phase = "R11";

   always #10 clk = ~clk;

   gpio_edge_ctrl u_dut (
      .clk_i (clk), .rst_i (rst),
      .wb_cyc_i (cyc), .wb_stb_i (stb), .wb_we_i (we),
      .wb_adr_i (adr), .wb_dat_i (wdat), .wb_dat_o (rdat), .wb_ack_o (ack),
      .gpio_i (pins), .aux_i (auxv), .ext_clk_i (eclk),
      .gpio_o (gout), .gpio_oe_o (goe), .irq_o (irq));

   // ---------------- behavioural reference ----------------
   logic [31:0] m_in, m_out, m_oe, m_inte, m_pol, m_aux, m_stat, m_pin, m_rdata;
   logic [3:0]  m_ctrl;
   logic        m_ack, m_was_rd, m_eprev;
   string       m_rtag;
   logic [31:0] pin_hist[$];
   logic        clk_hist[$];

   function automatic string tag_of(input logic [3:0] a);
      case (a)
         4'd0: return "R2 R4 IN";
         4'd1: return "R1 OUT";
         4'd2: return "R1 OE";
         4'd3: return "R1 INTE";
         4'd4: return "R1 POL";
         4'd5: return "R1 AUX";
         4'd6: return "R1 R9 CTRL";
         4'd7: return "R6 R9 STAT";
         default: return "R1 unmapped";
      endcase
   endfunction

   always @(posedge clk) begin
      if (rst) begin
         {m_in, m_out, m_oe, m_inte, m_pol, m_aux, m_stat, m_pin, m_rdata} = '0;
         m_ctrl = '0; m_ack = 0; m_was_rd = 0; m_eprev = 0;
         pin_hist.delete(); clk_hist.delete();
         repeat (SYNC) begin pin_hist.push_front('0); clk_hist.push_front(1'b0); end
      end else begin
         logic [31:0] seen, fresh, hit, rise, fall;
         logic        es, smp, take;
         seen  = pin_hist[$];
         es    = clk_hist[$];
         smp   = !m_ctrl[2] || ((es != m_eprev) && (es == !m_ctrl[3]));
         fresh = seen & ~m_oe;
         rise  = fresh & ~m_in;
         fall  = m_in & ~fresh;
         hit   = (smp && m_ctrl[0]) ? (((rise & m_pol) | (fall & ~m_pol)) & m_inte) : '0;
         take  = cyc && stb && !m_ack;
         m_was_rd = take && !we;
         if (take && !we) begin
            m_rtag = tag_of(adr);
            case (adr)
               4'd0: m_rdata = m_in | m_out;
               4'd1: m_rdata = m_out;
               4'd2: m_rdata = m_oe;
               4'd3: m_rdata = m_inte;
               4'd4: m_rdata = m_pol;
               4'd5: m_rdata = m_aux;
               4'd6: m_rdata = {28'd0, m_ctrl};
               4'd7: m_rdata = m_stat;
               default: m_rdata = '0;
            endcase
         end
         if (smp) begin
            m_pin = ((m_out & ~m_aux) | (auxv & m_aux)) & m_oe;
            m_in  = fresh;
         end
         if (take && we) begin
            case (adr)
               4'd1: m_out  = wdat;
               4'd2: m_oe   = wdat;
               4'd3: m_inte = wdat;
               4'd4: m_pol  = wdat;
               4'd5: m_aux  = wdat;
               4'd6: m_ctrl = wdat[3:0];
               4'd7: m_stat = wdat;
               default: ;
            endcase
         end
         m_stat = m_stat | hit;
         if (hit != 0) m_ctrl[1] = 1'b1;
         m_ack  = take;
         m_eprev = es;
         pin_hist.push_front(pins); void'(pin_hist.pop_back());
         clk_hist.push_front(eclk); void'(clk_hist.pop_back());
      end
   end

   task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
      vectors++;
      if (!ok) begin
         fails++;
         $display("FAIL %s [%s] t=%0t actual=%h expected=%h", req, phase, $time, act, exp);
      end
   endtask

   // compare every cycle at the falling edge: all outputs are registered
   always @(negedge clk) begin
      if (!rst) begin
         check(gout == m_pin, "R3 gpio_o", gout, m_pin);
         check(goe == m_oe, "R3 gpio_oe_o", goe, m_oe);
         check(irq == m_ctrl[1], "R6 irq_o", {31'd0, irq}, {31'd0, m_ctrl[1]});
         check(ack == m_ack, "R10 ack", {31'd0, ack}, {31'd0, m_ack});
         if (m_ack && m_was_rd) check(rdat == m_rdata, m_rtag, rdat, m_rdata);
      end
   end

   task automatic finish_run();
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
   endtask

   always @(posedge clk) begin
      ticks++;
      if (ticks > 150000) begin
         fails++;
         $display("FAIL R10 watchdog expired actual=%0d expected<150000", ticks);
         finish_run();
      end
   end

   task automatic bus(input bit w, input logic [3:0] a, input logic [31:0] d);
      @(negedge clk);
      cyc = 1; stb = 1; we = w; adr = a; wdat = d;
      do @(negedge clk); while (!ack);
      cyc = 0; stb = 0; we = 0;
   endtask

   task automatic wr(input logic [3:0] a, input logic [31:0] d); bus(1'b1, a, d); endtask
   task automatic rd(input logic [3:0] a); bus(1'b0, a, '0); endtask
   task automatic idle(input int n); repeat (n) @(negedge clk); endtask

   task automatic ext_edge(input logic v);
      @(negedge clk); eclk = v; idle(5);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      // R11: reset state at the ports
      check(gout == 0, "R11 gpio_o", gout, 0);
      check(irq == 0, "R11 irq_o", {31'd0, irq}, 0);
      check(ack == 0, "R11 ack", {31'd0, ack}, 0);
      rst = 0;
      for (int a = 0; a < 8; a++) rd(4'(a));

      phase = "R1";
      wr(4'd1, 32'hA5A5_3C3C); wr(4'd3, 32'h0F0F_0F0F); wr(4'd4, 32'h1234_5678);
      wr(4'd5, 32'h8000_0001); wr(4'd2, 32'hFFFF_0000); wr(4'd7, 32'h0000_0100);
      wr(4'd6, 32'h0000_0002);
      for (int a = 0; a < 16; a++) rd(4'(a));
      wr(4'd9, 32'hDEAD_BEEF); rd(4'd9); rd(4'd15);

      phase = "R2";
      wr(4'd0, 32'hFFFF_FFFF); rd(4'd0);
      wr(4'd6, 32'h0); wr(4'd7, 32'h0);

      phase = "R3";
      wr(4'd2, 32'h0000_FFFF); wr(4'd1, 32'h1234_5678); wr(4'd5, 32'h0000_00F0);
      auxv = 32'h0000_00A0; idle(3);
      auxv = 32'hFFFF_FF5F; idle(3);
      wr(4'd5, 32'h0); idle(2);

      phase = "R4";
      pins = 32'hCAFE_F00D; idle(1); rd(4'd0); idle(4); rd(4'd0);
      wr(4'd2, 32'h0); pins = 32'h0F0F_1234; idle(5); rd(4'd0);

      phase = "R5";
      wr(4'd3, 32'h0000_00FF); wr(4'd4, 32'h0000_000F);
      pins = 32'h0; idle(5);   // IE off: no event
      pins = 32'h0000_00FF; idle(5);
      wr(4'd6, 32'h1);
      pins = 32'h0000_0000; idle(5); rd(4'd7);   // falls fire bits 7:4
      pins = 32'h0000_00FF; idle(5); rd(4'd7);   // rises fire bits 3:0
      pins = 32'h0000_FF00; idle(5); rd(4'd7);   // masked bits

      phase = "R9";
      wr(4'd7, 32'h0); wr(4'd6, 32'h1); rd(4'd6);
      for (int k = 0; k < 6; k++) begin
         @(negedge clk); pins = (k % 2) ? 32'h0000_0001 : 32'h0;
         idle(k % 3);
         wr(4'd7, 32'h0); wr(4'd6, 32'h1); rd(4'd7);
      end

      phase = "R7";
      wr(4'd6, 32'h4); wr(4'd1, 32'h0000_0055); wr(4'd2, 32'h0000_00F0);
      pins = 32'h0000_0003; idle(6); rd(4'd0);
      wr(4'd1, 32'h0000_00AA); idle(4); rd(4'd0);
      ext_edge(1'b1); rd(4'd0);
      pins = 32'h0000_000C; ext_edge(1'b0); rd(4'd0);

      phase = "R8";
      wr(4'd6, 32'hD); wr(4'd4, 32'h0); wr(4'd3, 32'h0000_000F);
      ext_edge(1'b1); rd(4'd0);
      pins = 32'h0; ext_edge(1'b0); rd(4'd0); rd(4'd7);
      pins = 32'h0000_0005; ext_edge(1'b1); ext_edge(1'b0); rd(4'd0);
      wr(4'd6, 32'h5); pins = 32'h0; ext_edge(1'b1); rd(4'd7);

      idle(4);
      finish_run();
   end
endmodule